// File: doc/BRIEF.md
# Serial Command Framer with Device Address Match

This block is the serial slave front end of a two-channel digital trimmer controller. A host drives chip select, a serial clock and a data line. The block samples the data line on each rising serial-clock edge and drives its serial output on each falling edge. All four serial inputs are brought into the system clock domain through synchronizers, and edges are detected there. A frame starts when chip select falls. It consists of an identification byte, an instruction byte and, for write commands, one data byte. A frame can also stay open for a run of single-bit wiper steps.

The identification byte carries a fixed device-type nibble and two address bits. The address bits must match the strap pins. On any mismatch the block stays silent until chip select rises again. Decoded commands go to a downstream executor as items on a valid/ready stream. For reads, the executor returns the read value, and the block shifts it out on the serial output. A hold input can pause a transfer in the middle of a frame without losing position.

Top module: `spi_cmd_framer`

## Requirements
- R1: After reset, `cmd_valid`, `so_oe` and `byte_tick` are low.
- R2: After reset, no command is accepted until chip select has been seen high and then falls. A frame clocked in while chip select has stayed low since reset produces no item.
- R3: Identification byte layout, MSB first:
  - bits 7..4 must equal `TYPE_ID` (default 0101);
  - bits 3..2 must be 00;
  - bits 1..0 must equal `strap_addr`.
  On any mismatch the rest of the frame produces no item and no output drive.
- R4: The instruction byte carries the opcode in bits 7..4, the register select in bits 3..2 and the channel select in bits 1..0. Any opcode other than a read, a write or a step produces one item of kind CTRL (0) as soon as the instruction byte is complete, with those three fields and data 0.
- R5: Opcodes 1010 and 1100 are writes. One item of kind WRITE (2) is produced only once the third byte is complete, and its data is the low six bits of that byte.
- R6: If chip select rises before a byte is complete, the partial byte is discarded, and any write whose data byte has not finished produces no item.
- R7: Opcodes 1001, 1011 and 0101 are reads. Each produces one item of kind READ (1), with data 0, when the instruction byte is complete. The value on `rd_data` at the handshake of that item is shifted out, MSB first, as {00, rd_data}. It appears on `so` on the falling edges of the following byte, and `so_oe` is high during that byte.
- R8: `so_oe` is low whenever chip select is high.
- R9: Opcode 0010 opens a step run. Every following rising serial-clock edge produces one item of kind STEP (3). Its data bit 0 is the sampled data line (1 = up, 0 = down), and it carries the instruction's channel select.
- R10: Hold control:
  - Hold taken low while the serial clock is low pauses the frame. Clock edges are then ignored and `so_oe` is low.
  - Hold taken high while the serial clock is low resumes the frame at the same bit position.
- R11: While `cmd_valid` is high and `cmd_ready` is low, the item stays valid and unchanged. An item that arrives while one is still pending is dropped. The executor must therefore accept each item before the next one is due, which is at least one serial-clock period.
- R12: `byte_tick` pulses once for each complete byte of the identification, instruction, data or read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause control, active low |
| strap_addr | input | 2 | Device address strap pins |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (low = high impedance) |
| cmd_valid | output | 1 | Command item valid |
| cmd_ready | input | 1 | Executor accepts the item |
| cmd_kind | output | 2 | 0 CTRL, 1 READ, 2 WRITE, 3 STEP |
| cmd_op | output | 4 | Opcode |
| cmd_rsel | output | 2 | Register select |
| cmd_chan | output | 2 | Channel select |
| cmd_data | output | 6 | Write data, or step direction in bit 0 |
| rd_data | input | 6 | Read value, sampled at the READ item handshake |
| byte_tick | output | 1 | One-cycle pulse per complete byte |

## Verification
Frames are built from several patterns, and each is meant to separate one kind of fault:
- Two-byte control frames with distinct field values catch a swapped or shifted field.
- Write frames whose data byte has its upper bits set show that only six bits are kept.
- Read frames with a non-symmetric value show the bit order on the serial output.
- Step runs that mix up and down bits show that each edge is counted exactly once.

Negative frames separate the address check from normal decode: a wrong type nibble, a wrong strap value, nonzero reserved bits, chip select cut off mid-byte, and a frame sent before chip select has been seen high after reset. Hold pauses with serial-clock pulses inserted, and stretched back-pressure on the item stream, show that the frame position and a pending item both survive a stall.

// File: rtl/spi_framer_pkg.sv
package spi_framer_pkg;
  localparam int DATA_W  = 6;
  localparam int BYTE_W  = 8;
  localparam int BCNT_W  = $clog2(BYTE_W);

  localparam logic [3:0] OP_STEP     = 4'b0010;
  localparam logic [3:0] OP_RD_LIVE  = 4'b1001;
  localparam logic [3:0] OP_WR_LIVE  = 4'b1010;
  localparam logic [3:0] OP_RD_STORE = 4'b1011;
  localparam logic [3:0] OP_WR_STORE = 4'b1100;
  localparam logic [3:0] OP_STATUS   = 4'b0101;

  typedef enum logic [1:0] {
    K_CTRL  = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2,
    K_STEP  = 2'd3
  } item_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ID, S_INSTR, S_DATA, S_READ, S_STEP, S_SKIP
  } frame_state_e;

  function automatic logic op_is_write(input logic [3:0] op);
    return (op == OP_WR_LIVE) || (op == OP_WR_STORE);
  endfunction

  function automatic logic op_is_read(input logic [3:0] op);
    return (op == OP_RD_LIVE) || (op == OP_RD_STORE) || (op == OP_STATUS);
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
  import spi_framer_pkg::*;
#(
  parameter logic [3:0] TYPE_ID = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              si_s,
  input  logic              cs_n_s,
  input  logic              hold_n_s,
  input  logic [1:0]        strap,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output item_kind_e        cmd_kind,
  output logic [3:0]        cmd_op,
  output logic [1:0]        cmd_rsel,
  output logic [1:0]        cmd_chan,
  output logic [DATA_W-1:0] cmd_data,
  output logic              byte_tick,
  output logic              in_read,
  output logic              paused,
  output logic              frame_go,
  output logic              so_shift
);
  frame_state_e      state, st_n;
  logic [BCNT_W-1:0] bitcnt, bit_n;
  logic [BYTE_W-1:0] shreg, sh_n, byte_v;
  logic [3:0]        op_q, op_n;
  logic [1:0]        rs_q, rs_n, ch_q, ch_n;
  logic              sck_d, cs_d, pause_n;
  logic              sck_rise, sck_fall, cs_fall, active, advance, id_ok;
  logic              emit, tick;
  item_kind_e        e_kind;
  logic [3:0]        e_op;
  logic [1:0]        e_rs, e_ch;
  logic [DATA_W-1:0] e_dat;

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_fall  = ~cs_n_s & cs_d;
  assign active   = (state != S_IDLE);
  assign byte_v   = {shreg[BYTE_W-2:0], si_s};
  assign id_ok    = (byte_v[7:4] == TYPE_ID) && (byte_v[3:2] == 2'b00) &&
                    (byte_v[1:0] == strap);
  assign advance  = active && !paused && sck_rise;

  always_comb begin
    st_n   = state;
    bit_n  = bitcnt;
    sh_n   = shreg;
    op_n   = op_q;
    rs_n   = rs_q;
    ch_n   = ch_q;
    pause_n = paused;
    emit   = 1'b0;
    tick   = 1'b0;
    e_kind = K_CTRL;
    e_op   = op_q;
    e_rs   = rs_q;
    e_ch   = ch_q;
    e_dat  = '0;

    if (active && !sck_s) begin
      if (!paused && !hold_n_s)     pause_n = 1'b1;
      else if (paused && hold_n_s)  pause_n = 1'b0;
    end

    if (advance) begin
      case (state)
        S_ID, S_INSTR, S_DATA, S_READ: begin
          sh_n  = byte_v;
          bit_n = bitcnt + 1'b1;
          if (bitcnt == BCNT_W'(BYTE_W - 1)) begin
            tick  = 1'b1;
            bit_n = '0;
            case (state)
              S_ID: st_n = id_ok ? S_INSTR : S_SKIP;
              S_INSTR: begin
                op_n = byte_v[7:4];
                rs_n = byte_v[3:2];
                ch_n = byte_v[1:0];
                e_op = byte_v[7:4];
                e_rs = byte_v[3:2];
                e_ch = byte_v[1:0];
                if (op_is_write(byte_v[7:4])) begin
                  st_n = S_DATA;
                end else if (op_is_read(byte_v[7:4])) begin
                  emit = 1'b1; e_kind = K_READ; st_n = S_READ;
                end else if (byte_v[7:4] == OP_STEP) begin
                  st_n = S_STEP;
                end else begin
                  emit = 1'b1; e_kind = K_CTRL; st_n = S_SKIP;
                end
              end
              S_DATA: begin
                emit   = 1'b1;
                e_kind = K_WRITE;
                e_dat  = byte_v[DATA_W-1:0];
                st_n   = S_SKIP;
              end
              default: st_n = state;
            endcase
          end
        end
        S_STEP: begin
          emit     = 1'b1;
          e_kind   = K_STEP;
          e_dat    = DATA_W'(si_s);
        end
        default: st_n = state;
      endcase
    end

    if (cs_n_s) begin
      st_n    = S_IDLE;
      pause_n = 1'b0;
      emit    = 1'b0;
      tick    = 1'b0;
    end else if (cs_fall) begin
      st_n    = S_ID;
      bit_n   = '0;
      sh_n    = '0;
      pause_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      op_q      <= '0;
      rs_q      <= '0;
      ch_q      <= '0;
      paused    <= 1'b0;
      sck_d     <= 1'b0;
      cs_d      <= 1'b0;
      byte_tick <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_kind  <= K_CTRL;
      cmd_op    <= '0;
      cmd_rsel  <= '0;
      cmd_chan  <= '0;
      cmd_data  <= '0;
    end else begin
      state     <= st_n;
      bitcnt    <= bit_n;
      shreg     <= sh_n;
      op_q      <= op_n;
      rs_q      <= rs_n;
      ch_q      <= ch_n;
      paused    <= pause_n;
      sck_d     <= sck_s;
      cs_d      <= cs_n_s;
      byte_tick <= tick;
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
      if (emit && (!cmd_valid || cmd_ready)) begin
        cmd_valid <= 1'b1;
        cmd_kind  <= e_kind;
        cmd_op    <= e_op;
        cmd_rsel  <= e_rs;
        cmd_chan  <= e_ch;
        cmd_data  <= e_dat;
      end
    end
  end

  assign in_read  = (state == S_READ);
  assign frame_go = cs_fall;
  assign so_shift = in_read && !paused && sck_fall && !cs_n_s;
endmodule

// File: rtl/spi_so_shift.sv
module spi_so_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         so
);
  logic [W-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= '0;
      so <= 1'b0;
    end else if (clear) begin
      tx <= '0;
      so <= 1'b0;
    end else if (load) begin
      tx <= load_val;
    end else if (shift) begin
      so <= tx[W-1];
      tx <= {tx[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
  import spi_framer_pkg::*;
#(
  parameter logic [3:0] TYPE_ID     = 4'b0101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic [1:0]        strap_addr,
  output logic              so,
  output logic              so_oe,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [3:0]        cmd_op,
  output logic [1:0]        cmd_rsel,
  output logic [1:0]        cmd_chan,
  output logic [DATA_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] rd_data,
  output logic              byte_tick
);
  logic [3:0] raw_in, sync_out;
  logic       sck_s, si_s, cs_n_s, hold_n_s;
  logic       in_read, paused, frame_go, so_shift, rd_load;
  item_kind_e kind_e;

  assign raw_in = {hold_n, cs_n, si, sck};
  assign {hold_n_s, cs_n_s, si_s, sck_s} = sync_out;

  spi_in_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  spi_frame_fsm #(.TYPE_ID(TYPE_ID)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .si_s(si_s), .cs_n_s(cs_n_s),
    .hold_n_s(hold_n_s), .strap(strap_addr), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_kind(kind_e), .cmd_op(cmd_op),
    .cmd_rsel(cmd_rsel), .cmd_chan(cmd_chan), .cmd_data(cmd_data),
    .byte_tick(byte_tick), .in_read(in_read), .paused(paused),
    .frame_go(frame_go), .so_shift(so_shift)
  );

  assign cmd_kind = kind_e;
  assign rd_load  = cmd_valid && cmd_ready && (kind_e == K_READ);

  spi_so_shift #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(frame_go), .load(rd_load),
    .load_val(BYTE_W'(rd_data)), .shift(so_shift), .so(so)
  );

  assign so_oe = in_read && !paused && !cs_n_s;
endmodule

// File: rtl/spi_framer_checker.sv
module spi_framer_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [15:0] item,
  input logic        so_oe,
  input logic        in_read,
  input logic        paused
);
  // R11: a stalled item holds still
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(item));

  // R7: output drive only in the read data phase
  p_oe_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> in_read);

  // R10: nothing driven while paused
  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !so_oe);

  // R8: chip select high for long enough forces high impedance
  p_oe_off_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !so_oe);

  // R9: step items always carry the step opcode
  p_step_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && item[15:14] == 2'd3 |-> item[13:10] == 4'b0010);
endmodule

bind spi_cmd_framer spi_framer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .item({cmd_kind, cmd_op, cmd_rsel, cmd_chan, cmd_data}),
  .so_oe(so_oe), .in_read(in_read), .paused(paused)
);

// File: tb/tb_spi_cmd_framer.sv
module tb_spi_cmd_framer;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [7:0] ID_OK = {4'b0101, 2'b00, STRAP};

  logic clk = 0, rst_n = 0, cs_n = 0, sck = 0, si = 0, hold_n = 1;
  logic cmd_ready = 1;
  logic [5:0] rd_data = 6'h00;
  logic so, so_oe, cmd_valid, byte_tick;
  logic [1:0] cmd_kind, cmd_rsel, cmd_chan;
  logic [3:0] cmd_op;
  logic [5:0] cmd_data;

  int n_checks = 0, n_fail = 0, tick_cnt = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_framer dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .strap_addr(STRAP), .so(so), .so_oe(so_oe),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_op(cmd_op), .cmd_rsel(cmd_rsel), .cmd_chan(cmd_chan),
    .cmd_data(cmd_data), .rd_data(rd_data), .byte_tick(byte_tick)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the design hands them over
  always @(negedge clk) begin
    if (byte_tick) tick_cnt++;
    if (rst_n && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "unexpected item", {cmd_kind, cmd_op, cmd_rsel, cmd_chan, cmd_data}, 16'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({cmd_kind, cmd_op, cmd_rsel, cmd_chan, cmd_data} == e, t,
              {cmd_kind, cmd_op, cmd_rsel, cmd_chan, cmd_data}, e);
      end
    end
  end

  task automatic expect_item(input logic [1:0] k, input logic [7:0] instr, input logic [5:0] d, input string tag);
    exp_q.push_back({k, instr, d});
    tag_q.push_back(tag);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(input logic b, output logic sob);
    si = b;
    wait_clk(HALF);
    sob = so;
    sck = 1;
    wait_clk(HALF);
    sck = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic sb;
      send_bit(b[i], sb);
      r[i] = sb;
    end
  endtask

  task automatic frame_begin();
    cs_n = 1; wait_clk(2 * HALF);
    cs_n = 0; wait_clk(HALF);
  endtask

  task automatic frame_end();
    wait_clk(HALF);
    cs_n = 1;
    wait_clk(2 * HALF);
  endtask

  task automatic check_drained(input string tag);
    wait_clk(4);
    check(exp_q.size() == 0, tag, 16'(exp_q.size()), 16'h0);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic sb;
    int t0;
    wait_clk(3);
    rst_n = 1;
    wait_clk(2);
    #1;
    // R1: reset state
    check(!cmd_valid && !so_oe && !byte_tick, "R1 reset outputs",
          {13'h0, cmd_valid, so_oe, byte_tick}, 16'h0);

    // R2: chip select low since reset, no fall seen -> frame ignored
    send_byte(ID_OK, r);
    send_byte(8'b1101_10_01, r);
    frame_end();
    check_drained("R2 no command before first cs fall");

    // R4: two control frames with distinct fields
    frame_begin();
    expect_item(2'd0, 8'b1101_10_01, 6'h0, "R4 ctrl fields a");
    send_byte(ID_OK, r); send_byte(8'b1101_10_01, r);
    frame_end();
    check_drained("R4 ctrl a delivered");
    frame_begin();
    expect_item(2'd0, 8'b0001_11_00, 6'h0, "R4 ctrl fields b");
    send_byte(ID_OK, r); send_byte(8'b0001_11_00, r);
    frame_end();
    check_drained("R4 ctrl b delivered");

    // R3: mismatching identification bytes
    frame_begin(); send_byte(8'b0110_00_10, r); send_byte(8'b1101_10_01, r); frame_end();
    frame_begin(); send_byte(8'b0101_00_01, r); send_byte(8'b1101_10_01, r); frame_end();
    frame_begin(); send_byte(8'b0101_01_10, r); send_byte(8'b1101_10_01, r); frame_end();
    check_drained("R3 mismatched id ignored");

    // R5 + R12: writes, with upper data bits dropped; count byte strobes
    frame_begin();
    t0 = tick_cnt;
    expect_item(2'd2, 8'b1010_00_01, 6'h2A, "R5 write live");
    send_byte(ID_OK, r); send_byte(8'b1010_00_01, r);
    wait_clk(6);
    check(exp_q.size() == 1, "R5 no item before data byte", 16'(exp_q.size()), 16'h1);
    send_byte(8'h2A, r);
    frame_end();
    check(tick_cnt - t0 == 3, "R12 three byte strobes", 16'(tick_cnt - t0), 16'd3);
    frame_begin();
    expect_item(2'd2, 8'b1100_01_11, 6'h05, "R5 write store low six bits");
    send_byte(ID_OK, r); send_byte(8'b1100_01_11, r); send_byte(8'hC5, r);
    frame_end();
    check_drained("R5 writes delivered");

    // R6: cs cut mid data byte
    frame_begin();
    send_byte(ID_OK, r); send_byte(8'b1010_00_00, r);
    for (int i = 0; i < 4; i++) send_bit(1'b1, sb);
    frame_end();
    check_drained("R6 partial write dropped");

    // R7 + R8: read back a value
    rd_data = 6'h35;
    frame_begin();
    expect_item(2'd1, 8'b1011_10_01, 6'h0, "R7 read item");
    send_byte(ID_OK, r); send_byte(8'b1011_10_01, r);
    send_byte(8'h00, r);
    check(so_oe == 1'b1, "R7 so_oe during read byte", {15'h0, so_oe}, 16'h1);
    check(r == 8'h35, "R7 read value on so", {8'h0, r}, 16'h0035);
    frame_end();
    check(so_oe == 1'b0, "R8 so_oe off after cs high", {15'h0, so_oe}, 16'h0);

    // R10: hold pause in the middle of a read byte
    rd_data = 6'h2C;
    frame_begin();
    expect_item(2'd1, 8'b1001_00_01, 6'h0, "R10 read item with hold");
    send_byte(ID_OK, r); send_byte(8'b1001_00_01, r);
    for (int i = 7; i >= 4; i--) begin send_bit(1'b0, sb); r[i] = sb; end
    hold_n = 0;
    wait_clk(6);
    check(so_oe == 1'b0, "R10 so_oe off while held", {15'h0, so_oe}, 16'h0);
    for (int i = 0; i < 2; i++) begin
      sck = 1; wait_clk(HALF); sck = 0; wait_clk(HALF);
    end
    hold_n = 1;
    wait_clk(6);
    for (int i = 3; i >= 0; i--) begin send_bit(1'b0, sb); r[i] = sb; end
    check(r == 8'h2C, "R10 resumed at same bit", {8'h0, r}, 16'h002C);
    frame_end();
    check_drained("R10 items delivered");

    // R9: step run up, up, down
    frame_begin();
    expect_item(2'd3, 8'b0010_00_01, 6'h1, "R9 step 1 up");
    expect_item(2'd3, 8'b0010_00_01, 6'h1, "R9 step 2 up");
    expect_item(2'd3, 8'b0010_00_01, 6'h0, "R9 step 3 down");
    send_byte(ID_OK, r); send_byte(8'b0010_00_01, r);
    send_bit(1'b1, sb); send_bit(1'b1, sb); send_bit(1'b0, sb);
    frame_end();
    check_drained("R9 steps delivered");

    // R11: back-pressure holds the item
    cmd_ready = 0;
    frame_begin();
    send_byte(ID_OK, r); send_byte(8'b1110_10_00, r);
    frame_end();
    wait_clk(20);
    check(cmd_valid && {cmd_kind, cmd_op, cmd_rsel, cmd_chan, cmd_data} == {2'd0, 8'b1110_10_00, 6'h0},
          "R11 item held under stall", {cmd_kind, cmd_op, cmd_rsel, cmd_chan, cmd_data},
          {2'd0, 8'b1110_10_00, 6'h0});
    expect_item(2'd0, 8'b1110_10_00, 6'h0, "R11 item after release");
    @(negedge clk); cmd_ready = 1;
    check_drained("R11 item drained");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule